// File: doc/BRIEF.md
# Fractional M/N Clock-Enable Divider

This block produces a clock-enable pulse train for a clock root from a fast reference clock. Each cycle of the reference clock `clk` stands for half a period of the nominal input clock, so one input period is two `clk` cycles. A half-integer pre-divider scales the rate by 2/(div+1) by counting those half periods. When enabled, an M/N stage after it keeps exactly m of every n pre-divider pulses. The resulting output rate is the input rate × 2/(div+1) × m/n. A second output gives a waveform whose high fraction is set by the D value.

The configuration arrives already in its stored encodings. The M value is m itself. The N value holds the bitwise inverse of (n − m). The D value holds the bitwise inverse of the duty threshold. All three are masked to `MN_W` bits. A nonzero mode field requests the M/N stage. The stage is used only if that request is valid. The block holds a shadow copy of the configuration and takes a new copy only at an output-period boundary. This prevents a truncated or stretched pulse.

Top module: `frac_clk_div`

## Requirements
- R1: Without an active M/N stage, `out_en` pulses once every P cycles of `clk`, where P = div+1 for div ≥ 1 and P = 2 for div = 0 (bypass, the plain input rate).
- R2: `out_en` is never high in two consecutive cycles.
- R3: With mode ≠ 0, m = M, n = (~N & mask) + m, m ≠ 0 and n ≠ m, exactly m pulses of `out_en` occur in every n pre-divider periods. The long-run rate is m/(n·P) per cycle.
- R4: When the M/N stage is requested but m = 0 or m = n, the stage is not used, and the output behaves exactly as in R1.
- R5: With mode 0, the M, N and D values have no effect on `out_en` or `duty_out`.
- R6: With the M/N stage active, `duty_out` is high while the accumulator is below thr. Here thr = ~D & mask, clamped to 1..n−1. With gcd(m,n) = 1 the high fraction is thr/n. Without the stage, `duty_out` is high for the first floor(P/2) cycles of each pre-divider period.
- R7: The configuration inputs are sampled only at a boundary. Without M/N, a boundary is a pre-divider pulse. With M/N, it is the pulse that returns the accumulator to zero. A change made in the middle of a period therefore leaves that period's length intact.
- R8: During and after reset the shadow configuration is mode 0, div 0. During reset `out_en` is 0 and `duty_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, two cycles per nominal input period |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Pre-divider field, ratio 2/(div+1), 0 = bypass |
| cfg_mode | input | 2 | Nonzero requests the M/N stage |
| cfg_m | input | MN_W | m value |
| cfg_n_inv | input | MN_W | Inverse of (n − m) |
| cfg_d_inv | input | MN_W | Inverse of duty threshold |
| out_en | output | 1 | Divided clock-enable pulse |
| duty_out | output | 1 | Duty-cycle waveform |

## Verification
On every cycle the assertions check several local properties. Pulses never occur back to back. The half-period counter stays inside its period. The accumulator stays below n. Each output pulse coincides with a pre-divider tick. The shadow configuration changes only after a boundary. The duty threshold clamps at both ends. The long-run properties can only be shown by the bench's scenarios, which count pulses and duty-high cycles over windows. These cover the m/n and 2/(div+1) ratios, the duty fraction, the ignored M/N fields in mode 0 and the unharmed period after a mid-period change.

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int DIV_W = 5,
  parameter int MN_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_mode,
  input  logic [MN_W-1:0]  cfg_m,
  input  logic [MN_W-1:0]  cfg_n_inv,
  input  logic [MN_W-1:0]  cfg_d_inv,
  output logic             out_en,
  output logic             duty_out
);
  localparam int CW = DIV_W + 1;
  localparam int NW = MN_W + 1;
  localparam int SW = MN_W + 2;

  logic [DIV_W-1:0] sh_div;
  logic [1:0]       sh_mode;
  logic [MN_W-1:0]  sh_m, sh_n_inv, sh_d_inv;
  logic [CW-1:0]    cnt;
  logic [SW-1:0]    acc;

  logic [CW-1:0] period;
  logic [NW-1:0] n_val, thr;
  logic [SW-1:0] n_ext, sum;
  logic          active, pre_en, hit, wrap, load;

  assign period = (sh_div == '0) ? CW'(2) : CW'(sh_div) + CW'(1);
  assign n_val  = {1'b0, ~sh_n_inv} + {1'b0, sh_m};
  assign n_ext  = {1'b0, n_val};
  assign active = (sh_mode != 2'd0) && (sh_m != '0) && (n_val != {1'b0, sh_m});
  assign pre_en = (cnt == period - CW'(1));
  assign sum    = acc + {2'b0, sh_m};
  assign hit    = (sum >= n_ext);
  assign wrap   = (sum == n_ext);
  assign out_en = pre_en & (!active | hit);
  assign load   = pre_en & (!active | wrap);

  always_comb begin
    thr = {1'b0, ~sh_d_inv};
    if (thr == '0)
      thr = NW'(1);
    else if (thr >= n_val)
      thr = n_val - NW'(1);
  end

  assign duty_out = active ? (acc < {1'b0, thr}) : (cnt < (period >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_div   <= '0;
      sh_mode  <= '0;
      sh_m     <= '0;
      sh_n_inv <= '0;
      sh_d_inv <= '0;
      cnt      <= '0;
      acc      <= '0;
    end else if (load) begin
      sh_div   <= cfg_div;
      sh_mode  <= cfg_mode;
      sh_m     <= cfg_m;
      sh_n_inv <= cfg_n_inv;
      sh_d_inv <= cfg_d_inv;
      cnt      <= '0;
      acc      <= '0;
    end else if (pre_en) begin
      cnt <= '0;
      if (active)
        acc <= hit ? sum - n_ext : sum;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
  parameter int DIV_W = 5,
  parameter int MN_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               out_en,
  input logic               duty_out,
  input logic               pre_en,
  input logic               active,
  input logic               load,
  input logic [DIV_W+1-1:0] cnt,
  input logic [DIV_W+1-1:0] period,
  input logic [MN_W+2-1:0]  acc,
  input logic [MN_W+1-1:0]  n_val,
  input logic [DIV_W-1:0]   sh_div
);
  p_no_back_to_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |=> !out_en);

  p_cnt_in_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < period);

  p_acc_below_n_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (acc < {1'b0, n_val}));

  p_out_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> pre_en);

  p_cfg_at_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sh_div) |-> $past(load));

  p_duty_low_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && acc == '0) |-> duty_out);

  p_duty_high_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && acc == {1'b0, n_val - 1'b1}) |-> !duty_out);
endmodule

bind frac_clk_div frac_clk_div_chk #(.DIV_W(DIV_W), .MN_W(MN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_en(out_en), .duty_out(duty_out),
  .pre_en(pre_en), .active(active), .load(load), .cnt(cnt),
  .period(period), .acc(acc), .n_val(n_val), .sh_div(sh_div)
);

// File: tb/test_frac_clk_div.sv
`timescale 1ns/1ps
module test_frac_clk_div;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] cfg_div = '0;
  logic [1:0] cfg_mode = '0;
  logic [7:0] cfg_m = '0, cfg_n_inv = '0, cfg_d_inv = '0;
  logic       out_en, duty_out;
  int checks = 0, errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frac_clk_div i_frac_clk_div (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_mode(cfg_mode),
    .cfg_m(cfg_m), .cfg_n_inv(cfg_n_inv), .cfg_d_inv(cfg_d_inv),
    .out_en(out_en), .duty_out(duty_out));

  function automatic int pfun(input int div);
    return (div == 0) ? 2 : div + 1;
  endfunction

  function automatic bit act(input int mode, input int m, input int n);
    return (mode != 0) && (m != 0) && (n != m);
  endfunction

  function automatic int thrfun(input int thr, input int n);
    if (thr < 1) return 1;
    if (thr > n - 1) return n - 1;
    return thr;
  endfunction

  task automatic check(input string req, input int act_v, input int lo, input int hi);
    checks++;
    if (act_v < lo || act_v > hi) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d..%0d", req, act_v, lo, hi);
    end
  endtask

  task automatic setcfg(input int div, input int mode, input int m, input int n, input int thr);
    @(negedge clk);
    cfg_div   = 5'(div);
    cfg_mode  = 2'(mode);
    cfg_m     = 8'(m);
    cfg_n_inv = ~8'(n - m);
    cfg_d_inv = ~8'(thr);
    repeat (1000) @(negedge clk);
  endtask

  task automatic measure(input int w, output int pulses, output int highs);
    pulses = 0; highs = 0;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (out_en) pulses++;
      if (duty_out) highs++;
    end
  endtask

  task automatic run_rate(input string req, input int div, input int mode,
                          input int m, input int n, input int thr, input bit chk_duty);
    int p, e, pu, hi, w, t, tol;
    w = 5000;
    setcfg(div, mode, m, n, thr);
    measure(w, pu, hi);
    p = pfun(div);
    if (act(mode, m, n)) begin
      e = (w * m) / (p * n);
      t = thrfun(thr, n);
      tol = p * n;
      check(req, pu, e - 1, e + 1);
      if (chk_duty) check({req, " duty R6"}, hi, (w * t) / n - tol, (w * t) / n + tol);
    end else begin
      e = w / p;
      check(req, pu, e - 1, e + 1);
      if (chk_duty) check({req, " duty R6"}, hi, (w * (p / 2)) / p - p, (w * (p / 2)) / p + p);
    end
  endtask

  task automatic next_pulse(output int t);
    @(negedge clk);
    while (!out_en) @(negedge clk);
    t = cyc;
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t0, t1, t2, pu, hi;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R8 out_en in reset", int'(out_en), 0, 0);
    check("R8 duty in reset", int'(duty_out), 1, 1);
    rst_n = 1'b1;
    measure(40, pu, hi);
    check("R8 initial bypass rate", pu, 19, 21);

    run_rate("R1 div0 bypass", 0, 0, 0, 0, 0, 1);
    run_rate("R1 div1", 1, 0, 0, 0, 0, 0);
    run_rate("R1 div7 half-integer", 7, 0, 0, 0, 0, 1);
    run_rate("R5 mode0 ignores m/n/d", 4, 0, 3, 7, 2, 1);
    run_rate("R4 m equals n", 3, 2, 5, 5, 2, 1);
    run_rate("R4 m zero", 2, 2, 0, 9, 2, 0);
    run_rate("R3 m3 n8", 2, 2, 3, 8, 4, 1);
    run_rate("R6 thr clamp high", 0, 2, 3, 8, 8, 1);
    run_rate("R6 thr clamp low", 0, 2, 5, 7, 0, 1);

    setcfg(9, 0, 0, 0, 0);
    next_pulse(t0);
    repeat (3) @(negedge clk);
    cfg_div = 5'd3;
    next_pulse(t1);
    next_pulse(t2);
    check("R7 old period kept", t1 - t0, 10, 10);
    check("R7 new period after boundary", t2 - t1, 4, 4);

    for (int k = 0; k < 8; k++) begin
      int d, md, m, n;
      d  = $urandom_range(0, 15);
      md = $urandom_range(0, 3);
      m  = $urandom_range(0, 40);
      n  = ($urandom_range(0, 3) == 0) ? m : $urandom_range(m + 1, 41);
      run_rate("R3 random", d, md, m, n, $urandom_range(0, 45), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule